// File: doc/BRIEF.md
# Memory-Mapped Configuration Access Translator

This block sits between a host memory-request port and two destinations: the normal memory path and a downstream configuration port. It compares each host request against a 256 MB window whose position is held in a programmable base register and whose decoding is switched by an enable bit. Requests that land inside an enabled window are converted into configuration reads or writes. The window offset is split into bus, device, function and dword register number, and the byte enables carry the low two offset bits. Every other request is forwarded to the memory path with its fields untouched.

A host write that hits the window is accepted at once and gets no host response, so it is posted. Downstream, however, it becomes a configuration write that waits for a completion. Only one configuration request is in flight at a time. Until that request completes, all new host requests stall, so later reads and writes cannot pass it. A configuration read returns its completion data to the host one cycle after the completion arrives. A read that completes as unsupported returns all-ones.

Top module: `cfg_window_xlat`

## Requirements
- R1: After reset the enable bit is clear and the base is 0, so every host request, including one with address bits 31:28 equal to 0, is forwarded to the memory path.
- R2: A control write with `ctl_sel_i`=0 sets the enable bit to bit 31 of the control word (`ctl_wdata_i[31]`). Writing it to 0 disables decoding again.
- R3: A control write with `ctl_sel_i`=1 loads bits 31:28 of the control word as the window base. A request hits only when enabled and when its address bits 31:28 equal the base.
- R4: For a hit, the downstream request carries bus = address bits 27:20, device = bits 19:15, function = bits 14:12, dword register number = bits 11:2, and the host byte enables unchanged.
- R5: `cfg_ext_o` is 1 exactly when offset bits 11:8 are nonzero, which means the offset is at 0x100 or above (extended space). It is 0 for offsets 0x000 to 0x0FF.
- R6: A window write is accepted (`host_rdy_o`=1) in the first idle cycle it is presented and never produces a host response. Downstream it appears one cycle later with `cfg_we_o`=1 and the host write data.
- R7: A window read becomes a downstream request with `cfg_we_o`=0. The cycle after `cpl_vld_i` is seen, `host_rsp_vld_o` pulses for one cycle with `cpl_data_i`.
- R8: A read completion with `cpl_ur_i`=1 returns 0xFFFFFFFF to the host.
- R9: From the acceptance of a window hit until its completion cycle, `host_rdy_o` and `mem_vld_o` are 0 for every host request. After the downstream handshake, `cfg_vld_o` stays low until a new hit is accepted.
- R10: While idle, a request that misses the window drives `mem_vld_o`=1 in the same cycle with identical address, write flag, byte enables and data, and `host_rdy_o` follows `mem_rdy_i`.
- R11: While `cfg_vld_o`=1 and `cfg_rdy_i`=0, the downstream request and all its fields hold steady.
- R12: A completion that arrives while no request is awaiting one produces no host response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_sel_i | input | 1 | 0: enable word, 1: base word |
| ctl_wdata_i | input | 4 | Bits 31:28 of the control word |
| host_vld_i | input | 1 | Host request valid |
| host_rdy_o | output | 1 | Host request accepted |
| host_we_i | input | 1 | Host request is a write |
| host_addr_i | input | 30 | Host dword address (byte address bits 31:2) |
| host_be_i | input | 4 | Host byte enables |
| host_wdata_i | input | 32 | Host write data |
| host_rsp_vld_o | output | 1 | Configuration read data valid |
| host_rsp_data_o | output | 32 | Configuration read data |
| mem_vld_o | output | 1 | Memory path request valid |
| mem_rdy_i | input | 1 | Memory path ready |
| mem_we_o | output | 1 | Memory path write flag |
| mem_addr_o | output | 30 | Memory path dword address |
| mem_be_o | output | 4 | Memory path byte enables |
| mem_wdata_o | output | 32 | Memory path write data |
| cfg_vld_o | output | 1 | Configuration request valid |
| cfg_rdy_i | input | 1 | Configuration request accepted |
| cfg_we_o | output | 1 | Configuration write |
| cfg_bus_o | output | 8 | Bus number |
| cfg_dev_o | output | 5 | Device number |
| cfg_fn_o | output | 3 | Function number |
| cfg_reg_o | output | 10 | Dword register number |
| cfg_ext_o | output | 1 | Extended-space offset |
| cfg_be_o | output | 4 | Configuration byte enables |
| cfg_wdata_o | output | 32 | Configuration write data |
| cpl_vld_i | input | 1 | Configuration completion valid |
| cpl_ur_i | input | 1 | Completion is unsupported request |
| cpl_data_i | input | 32 | Completion read data |

## Verification
A wrong tracker state shows at the ports within one cycle. A tracker stuck busy holds `host_rdy_o` low for every later request. A tracker that falls back to idle too early re-raises `host_rdy_o` or `cfg_vld_o` before the completion, or sends a read response with no completion behind it. A bad enable or base register sends a request to the wrong path in the same cycle it is presented. A bad field split shows as a mismatched bus, device, function or register number on the first downstream cycle. The bench sweeps all device and function numbers, together with a spread of bus numbers, offsets, byte enables and completion statuses.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int DW      = 32;
  localparam int BE_W    = DW / 8;
  localparam int FN_W    = 3;
  localparam int DEV_W   = 5;
  localparam int BUS_W   = 8;
  localparam int FN_LSB  = 12;
  localparam int DEV_LSB = FN_LSB + FN_W;
  localparam int BUS_LSB = DEV_LSB + DEV_W;
  localparam int WIN_LSB = BUS_LSB + BUS_W;
  localparam int REG_W   = FN_LSB - 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} trk_st_e;

  typedef struct packed {
    logic             we;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] regn;
    logic             ext;
    logic [BE_W-1:0]  be;
    logic [DW-1:0]    data;
  } cfg_req_t;
endpackage

// File: rtl/cfgx_ctl_regs.sv
module cfgx_ctl_regs
  import cfgx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                sel_i,
  input  logic [AW-1:WIN_LSB] wdata_i,
  output logic                en_o,
  output logic [AW-1:WIN_LSB] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      base_o <= '0;
    end else if (we_i) begin
      if (sel_i) base_o <= wdata_i;
      else       en_o   <= wdata_i[AW-1];
    end
  end
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                en_i,
  input  logic [AW-1:WIN_LSB] base_i,
  input  logic [AW-1:2]       addr_i,
  input  logic                we_i,
  input  logic [BE_W-1:0]     be_i,
  input  logic [DW-1:0]       wdata_i,
  output logic                hit_o,
  output cfg_req_t            req_o
);
  assign hit_o = en_i && (addr_i[AW-1:WIN_LSB] == base_i);

  always_comb begin
    req_o.we   = we_i;
    req_o.bus  = addr_i[WIN_LSB-1:BUS_LSB];
    req_o.dev  = addr_i[BUS_LSB-1:DEV_LSB];
    req_o.fn   = addr_i[DEV_LSB-1:FN_LSB];
    req_o.regn = addr_i[FN_LSB-1:2];
    req_o.ext  = |addr_i[FN_LSB-1:8];
    req_o.be   = be_i;
    req_o.data = wdata_i;
  end
endmodule

// File: rtl/cfgx_track.sv
module cfgx_track
  import cfgx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          host_vld_i,
  input  cfg_req_t      req_i,
  input  logic          cfg_rdy_i,
  input  logic          cpl_vld_i,
  input  logic          cpl_ur_i,
  input  logic [DW-1:0] cpl_data_i,
  output logic          busy_o,
  output logic          cfg_vld_o,
  output cfg_req_t      req_o,
  output logic          rsp_vld_o,
  output logic [DW-1:0] rsp_data_o
);
  trk_st_e st_q;

  assign busy_o    = (st_q != ST_IDLE);
  assign cfg_vld_o = (st_q == ST_ISSUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      req_o      <= '0;
      rsp_vld_o  <= 1'b0;
      rsp_data_o <= '0;
    end else begin
      rsp_vld_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (host_vld_i && hit_i) begin
          req_o <= req_i;
          st_q  <= ST_ISSUE;
        end
        ST_ISSUE: if (cfg_rdy_i) st_q <= ST_WAIT;
        ST_WAIT: if (cpl_vld_i) begin
          // writes were posted upstream: no response
          rsp_vld_o  <= !req_o.we;
          rsp_data_o <= cpl_ur_i ? '1 : cpl_data_i;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_window_xlat.sv
module cfg_window_xlat
  import cfgx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctl_we_i,
  input  logic                    ctl_sel_i,
  input  logic [AW-1:WIN_LSB]     ctl_wdata_i,
  input  logic                    host_vld_i,
  output logic                    host_rdy_o,
  input  logic                    host_we_i,
  input  logic [AW-1:2]           host_addr_i,
  input  logic [BE_W-1:0]         host_be_i,
  input  logic [DW-1:0]           host_wdata_i,
  output logic                    host_rsp_vld_o,
  output logic [DW-1:0]           host_rsp_data_o,
  output logic                    mem_vld_o,
  input  logic                    mem_rdy_i,
  output logic                    mem_we_o,
  output logic [AW-1:2]           mem_addr_o,
  output logic [BE_W-1:0]         mem_be_o,
  output logic [DW-1:0]           mem_wdata_o,
  output logic                    cfg_vld_o,
  input  logic                    cfg_rdy_i,
  output logic                    cfg_we_o,
  output logic [BUS_W-1:0]        cfg_bus_o,
  output logic [DEV_W-1:0]        cfg_dev_o,
  output logic [FN_W-1:0]         cfg_fn_o,
  output logic [REG_W-1:0]        cfg_reg_o,
  output logic                    cfg_ext_o,
  output logic [BE_W-1:0]         cfg_be_o,
  output logic [DW-1:0]           cfg_wdata_o,
  input  logic                    cpl_vld_i,
  input  logic                    cpl_ur_i,
  input  logic [DW-1:0]           cpl_data_i
);
  logic                en;
  logic [AW-1:WIN_LSB] base;
  logic                hit, busy;
  cfg_req_t            req_d, req_q;

  cfgx_ctl_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(ctl_we_i), .sel_i(ctl_sel_i), .wdata_i(ctl_wdata_i),
    .en_o(en), .base_o(base)
  );

  cfgx_decode #(.AW(AW)) u_dec (
    .en_i(en), .base_i(base), .addr_i(host_addr_i), .we_i(host_we_i),
    .be_i(host_be_i), .wdata_i(host_wdata_i), .hit_o(hit), .req_o(req_d)
  );

  cfgx_track u_trk (
    .clk_i, .rst_ni, .hit_i(hit), .host_vld_i, .req_i(req_d), .cfg_rdy_i,
    .cpl_vld_i, .cpl_ur_i, .cpl_data_i, .busy_o(busy), .cfg_vld_o,
    .req_o(req_q), .rsp_vld_o(host_rsp_vld_o), .rsp_data_o(host_rsp_data_o)
  );

  // everything stalls behind an outstanding configuration request
  assign host_rdy_o  = !busy && (hit || mem_rdy_i);
  assign mem_vld_o   = host_vld_i && !busy && !hit;
  assign mem_we_o    = host_we_i;
  assign mem_addr_o  = host_addr_i;
  assign mem_be_o    = host_be_i;
  assign mem_wdata_o = host_wdata_i;

  assign cfg_we_o    = req_q.we;
  assign cfg_bus_o   = req_q.bus;
  assign cfg_dev_o   = req_q.dev;
  assign cfg_fn_o    = req_q.fn;
  assign cfg_reg_o   = req_q.regn;
  assign cfg_ext_o   = req_q.ext;
  assign cfg_be_o    = req_q.be;
  assign cfg_wdata_o = req_q.data;
endmodule

module cfgx_chk
  import cfgx_pkg::*;
#(
  parameter int AW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            host_vld_i,
  input logic            host_rdy_o,
  input logic [AW-1:2]   host_addr_i,
  input logic            host_we_i,
  input logic            host_rsp_vld_o,
  input logic            mem_vld_o,
  input logic            mem_rdy_i,
  input logic            mem_we_o,
  input logic [AW-1:2]   mem_addr_o,
  input logic            cfg_vld_o,
  input logic            cfg_rdy_i,
  input logic            cfg_we_o,
  input logic [BUS_W-1:0] cfg_bus_o,
  input logic [DEV_W-1:0] cfg_dev_o,
  input logic [FN_W-1:0]  cfg_fn_o,
  input logic [REG_W-1:0] cfg_reg_o,
  input logic [BE_W-1:0]  cfg_be_o,
  input logic [DW-1:0]    cfg_wdata_o,
  input logic             cpl_vld_i
);
  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_vld_o && !cfg_rdy_i |=> cfg_vld_o &&
      $stable({cfg_we_o, cfg_bus_o, cfg_dev_o, cfg_fn_o, cfg_reg_o, cfg_be_o, cfg_wdata_o}));
  // R9
  cfg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_vld_o && cfg_rdy_i |=> !cfg_vld_o);
  // R9
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_vld_o |-> !host_rdy_o && !mem_vld_o);
  // R7
  rsp_after_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rsp_vld_o |-> $past(cpl_vld_i));
  // R7
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rsp_vld_o |=> !host_rsp_vld_o);
  // R10
  pass_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_vld_o |-> host_vld_i && mem_addr_o == host_addr_i &&
      mem_we_o == host_we_i && host_rdy_o == mem_rdy_i);
endmodule

bind cfg_window_xlat cfgx_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .host_vld_i, .host_rdy_o, .host_addr_i, .host_we_i,
  .host_rsp_vld_o, .mem_vld_o, .mem_rdy_i, .mem_we_o, .mem_addr_o,
  .cfg_vld_o, .cfg_rdy_i, .cfg_we_o, .cfg_bus_o, .cfg_dev_o, .cfg_fn_o,
  .cfg_reg_o, .cfg_be_o, .cfg_wdata_o, .cpl_vld_i
);

// File: tb/sim_cfg_window_xlat.sv
`timescale 1ns/1ps
module sim_cfg_window_xlat;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0;
  logic ctl_we = 0, ctl_sel = 0;
  logic [3:0] ctl_wdata = 0;
  logic host_vld = 0, host_we = 0;
  logic [31:0] host_a = 0;
  logic [3:0] host_be = 0;
  logic [31:0] host_wdata = 0;
  logic host_rdy, rsp_vld;
  logic [31:0] rsp_data;
  logic mem_vld, mem_rdy = 0, mem_we;
  logic [31:2] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic cfg_vld, cfg_rdy = 0, cfg_we, cfg_ext;
  logic [7:0] cfg_bus;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_fn;
  logic [9:0] cfg_reg;
  logic [3:0] cfg_be;
  logic [31:0] cfg_wdata;
  logic cpl_vld = 0, cpl_ur = 0;
  logic [31:0] cpl_data = 0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit en_m = 0;
  logic [3:0] base_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_window_xlat u0 (
    .clk_i(clk), .rst_ni, .ctl_we_i(ctl_we), .ctl_sel_i(ctl_sel), .ctl_wdata_i(ctl_wdata),
    .host_vld_i(host_vld), .host_rdy_o(host_rdy), .host_we_i(host_we),
    .host_addr_i(host_a[31:2]), .host_be_i(host_be), .host_wdata_i(host_wdata),
    .host_rsp_vld_o(rsp_vld), .host_rsp_data_o(rsp_data),
    .mem_vld_o(mem_vld), .mem_rdy_i(mem_rdy), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .cfg_vld_o(cfg_vld), .cfg_rdy_i(cfg_rdy), .cfg_we_o(cfg_we), .cfg_bus_o(cfg_bus),
    .cfg_dev_o(cfg_dev), .cfg_fn_o(cfg_fn), .cfg_reg_o(cfg_reg), .cfg_ext_o(cfg_ext),
    .cfg_be_o(cfg_be), .cfg_wdata_o(cfg_wdata),
    .cpl_vld_i(cpl_vld), .cpl_ur_i(cpl_ur), .cpl_data_i(cpl_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      report();
    end
  end

  task automatic ctl_write(input bit sel, input logic [3:0] v);
    @(negedge clk);
    ctl_we = 1; ctl_sel = sel; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 0;
    if (sel) base_m = v; else en_m = v[3];
  endtask

  // miss or disabled access: forwarded in the same cycle
  task automatic pass_chk(input logic [31:0] a, input bit we, input bit rdy, input string tag);
    @(negedge clk);
    host_vld = 1; host_a = a; host_we = we; host_be = a[7:4];
    host_wdata = ~a; mem_rdy = rdy;
    #1;
    chk(mem_vld === 1'b1 && mem_addr === a[31:2] && mem_we === we &&
        mem_be === a[7:4] && mem_wdata === ~a, {tag, " mem fwd"}, {mem_addr, 2'b00}, a);
    chk(host_rdy === rdy, {tag, " rdy"}, 32'(host_rdy), 32'(rdy));
    @(negedge clk);
    host_vld = 0; mem_rdy = 0;
  endtask

  task automatic cfg_txn(input logic [31:0] a, input bit we, input logic [3:0] be,
                         input logic [31:0] wd, input bit ur, input logic [31:0] cd,
                         input int hold);
    logic [31:0] exp_rd;
    @(negedge clk);
    host_vld = 1; host_a = a; host_we = we; host_be = be; host_wdata = wd;
    #1;
    chk(host_rdy === 1'b1 && mem_vld === 1'b0, "R6 R3 hit accepted", 32'(host_rdy), 1);
    @(negedge clk);
    host_vld = 0;
    chk(cfg_vld === 1'b1, "R6 cfg issued", 32'(cfg_vld), 1);
    chk(cfg_bus === a[27:20] && cfg_dev === a[19:15] && cfg_fn === a[14:12],
        "R4 bus/dev/fn", {8'h0, cfg_bus, 3'h0, cfg_dev, 5'h0, cfg_fn}, {8'h0, a[27:20], 3'h0, a[19:15], 5'h0, a[14:12]});
    chk(cfg_reg === a[11:2] && cfg_be === be, "R4 reg/be", {cfg_reg, 2'b00}, {a[11:2], 2'b00});
    chk(cfg_ext === (a[11:0] >= 12'h100), "R5 ext", 32'(cfg_ext), 32'(a[11:0] >= 12'h100));
    chk(cfg_we === we && (!we || cfg_wdata === wd), "R6 R7 we/data", cfg_wdata, wd);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(cfg_vld === 1'b1 && cfg_reg === a[11:2] && cfg_bus === a[27:20],
          "R11 hold", {cfg_reg, 2'b00}, {a[11:2], 2'b00});
    end
    cfg_rdy = 1;
    @(negedge clk);
    cfg_rdy = 0;
    chk(cfg_vld === 1'b0, "R9 single outstanding", 32'(cfg_vld), 0);
    // any new request must stall, hit or miss
    host_vld = 1; host_a = {~base_m, a[27:0]}; host_we = 0; mem_rdy = 1;
    #1;
    chk(host_rdy === 1'b0 && mem_vld === 1'b0, "R9 stall", {host_rdy, mem_vld}, 0);
    chk(rsp_vld === 1'b0, "R6 no rsp before cpl", 32'(rsp_vld), 0);
    cpl_vld = 1; cpl_ur = ur; cpl_data = cd;
    @(negedge clk);
    cpl_vld = 0; cpl_ur = 0; host_vld = 0; mem_rdy = 0;
    exp_rd = ur ? 32'hFFFF_FFFF : cd;
    if (we) chk(rsp_vld === 1'b0, "R6 posted no rsp", 32'(rsp_vld), 0);
    else begin
      chk(rsp_vld === 1'b1, "R7 rsp valid", 32'(rsp_vld), 1);
      chk(rsp_data === exp_rd, ur ? "R8 ur all-ones" : "R7 rsp data", rsp_data, exp_rd);
    end
    @(negedge clk);
    chk(rsp_vld === 1'b0, "R7 rsp one cycle", 32'(rsp_vld), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(cfg_vld === 1'b0 && rsp_vld === 1'b0 && mem_vld === 1'b0, "R1 reset outputs",
        {cfg_vld, rsp_vld, mem_vld}, 0);
    pass_chk(32'h0000_1004, 0, 1, "R1 base0 disabled");
    pass_chk(32'h0123_4568, 1, 0, "R1 disabled");
    ctl_write(1, 4'hE);
    pass_chk(32'hE010_8000, 0, 1, "R2 base set not enabled");
    ctl_write(0, 4'h8);
    cfg_txn(32'hE000_0000, 0, 4'hF, 0, 0, 32'h8086_1234, 0);
    pass_chk(32'hD000_0000, 1, 1, "R3 R10 miss below");
    pass_chk(32'hF000_0100, 0, 0, "R3 R10 miss above");
    ctl_write(0, 4'h7);
    pass_chk(32'hE010_8000, 0, 1, "R2 cleared");
    ctl_write(0, 4'h8);
    // corner offsets and fields
    cfg_txn(32'hEFFF_FFFC, 1, 4'h8, 32'hA5A5_0001, 0, 0, 2);
    cfg_txn(32'hE000_00FC, 0, 4'h1, 0, 0, 32'h0000_00FF, 0);
    cfg_txn(32'hE000_0100, 0, 4'h3, 0, 1, 32'h1234_5678, 1);
    // R12 stray completion
    @(negedge clk);
    cpl_vld = 1; cpl_data = 32'hDEAD_BEEF;
    @(negedge clk);
    cpl_vld = 0;
    chk(rsp_vld === 1'b0, "R12 stray cpl ignored", 32'(rsp_vld), 0);
    // sweep every device and function
    for (int d = 0; d < 32; d++) begin
      for (int f = 0; f < 8; f++) begin
        logic [31:0] a;
        a = {base_m, 8'((d * 7 + f * 37) & 255), 5'(d), 3'(f), 12'(((d * 131 + f * 29) * 4) & 12'hFFC)};
        cfg_txn(a, f[0], 4'(1 << (d % 4)) | 4'(f[1] ? 4'hC : 4'h0), 32'(d * 1000 + f),
                (d % 5) == 0, 32'(d * 65536 + f * 17), (d + f) % 3);
      end
      pass_chk({~base_m, 28'(d * 4096 + 4)}, d[0], d[1], "R10 sweep miss");
    end
    // move the window
    ctl_write(1, 4'h3);
    pass_chk(32'hE000_0000, 0, 1, "R3 old base misses");
    cfg_txn(32'h3ABC_D124, 0, 4'hF, 0, 0, 32'h0BAD_F00D, 0);
    report();
  end
endmodule